// File: doc/BRIEF.md
# Vendor Host-Control Register Remapper

This block sits on the register path between a bus slave port and a standard SD host controller register file. Software that was written for a vendor register layout issues its accesses upstream. The block rewrites, absorbs or forwards each access so that the standard register file downstream sees the standard layout. Reads come back through the same translation in reverse, in the same cycle.

Most addresses pass straight through. Five kinds of access are handled specially:
- The host-control word has its bit positions re-encoded in both directions.
- A vendor mixed-control register holds the transfer mode in a local cache. A write to it does not reach the standard controller, so it cannot start a command there.
- A later write to the transfer-mode/command word picks up the cached mode.
- Block-size writes have the DMA boundary field forced to its largest setting.
- A set of vendor-only registers reads as zero, and writes to them are dropped.

Accesses are one word wide (32 bits) with byte enables, so 1-, 2- and 4-byte accesses are possible. Bit positions below are word bit positions, with byte lane n holding bits 8n+7:8n (little-endian). The standard power-control byte is an input from the register file.

Top module: `vhc_remap`

## Requirements
- R1: An access to any address that is not one of the special registers is forwarded unchanged, with the same write flag, address, byte enables and data. For such a read, the read data returned upstream equals the downstream read data.
- R2: On a host-control write, the forwarded bits 7:0 are built from the upstream word as follows:
  - bit0 is taken from upstream bit0, and bits 7:6 from upstream bits 7:6.
  - bit1 is taken from upstream bit1 (4-bit width).
  - bit5 is taken from upstream bit2 (8-bit width).
  - bits 4:3 are taken from upstream bits 9:8 (DMA select).
  - bit2 is 0.
- R3: On a host-control write, the forwarded bits 15:8 equal the standard power-control input, and bits 31:16 equal the upstream bits 31:16. The byte enables are unchanged.
- R4: A host-control read returns a word built from the downstream word d:
  - bits 9:8 are d[4:3].
  - bit1 is d[1], and bit2 is d[5].
  - bits 23:16 are d[23:16], and bits 31:24 are d[31:24].
  - every other bit is 0.
- R5: A write to the mixed-control register stores upstream bits 7:0 and 15:8 into the cached transfer mode, each byte only where its byte enable is set, and is not forwarded. A read of the mixed-control register returns 0 and is not forwarded.
- R6: A write to the transfer-mode/command word that enables lane 2 or lane 3 is forwarded with lanes 0 and 1 also enabled. The forwarded bits 15:0 are the cached mode ORed with the upstream bits 15:0 of the enabled lanes. Bits 31:16 pass through unchanged.
- R7: A write to the block-size word is forwarded with bits 14:12 set to 3'b111, the 512 KiB boundary code. All other bits and the byte enables are unchanged.
- R8: For the five vendor-only registers (delay-line control, tuning status, tuning control, vendor-specific, watermark), a read returns 0, a write is dropped, and nothing is forwarded downstream.
- R9: After reset, the cached transfer mode is zero. A command-word write with zero low data is therefore forwarded with bits 15:0 equal to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| up_valid | input | 1 | Upstream access request this cycle |
| up_write | input | 1 | 1 = write, 0 = read |
| up_addr | input | ADDR_W | Upstream byte address |
| up_be | input | 4 | Upstream byte enables |
| up_wdata | input | 32 | Upstream write data |
| up_rdata | output | 32 | Read data returned upstream (same cycle) |
| std_power | input | 8 | Current standard power-control byte |
| dn_valid | output | 1 | Forwarded access request |
| dn_write | output | 1 | Forwarded write flag |
| dn_addr | output | ADDR_W | Forwarded byte address |
| dn_be | output | 4 | Forwarded byte enables |
| dn_wdata | output | 32 | Forwarded write data |
| dn_rdata | input | 32 | Downstream read data (combinational) |

## Verification
The cached transfer mode is the block's only state. If it is wrong, the error shows up on the first command-word write after the bad mixed-control write. The forwarded low half then carries the wrong mode bits in that same cycle, and nothing else on the ports reveals it any sooner. A wrong address decode or bit placement is purely combinational, so it is visible on the forwarded word or the returned read data of the very access that hits it. For that reason, every access is compared against the reference in the cycle it is issued.

// File: rtl/vhc_remap_pkg.sv
`timescale 1ns/1ps
package vhc_remap_pkg;

  localparam int WORD_W = 32;
  localparam int LANES  = WORD_W / 8;
  localparam int MODE_W = 16;

  typedef enum logic [2:0] {
    K_PASS,
    K_HOSTCTL,
    K_MIXCTL,
    K_XFERCMD,
    K_BLKSIZE,
    K_VENDOR
  } acc_kind_e;

  // Vendor host-control halfword -> standard host-control byte.
  function automatic logic [7:0] hc_vendor_to_std(input logic [15:0] v);
    logic [7:0] s;
    s      = '0;
    s[0]   = v[0];      // LED
    s[1]   = v[1];      // 4-bit width
    s[5]   = v[2];      // 8-bit width
    s[4:3] = v[9:8];    // DMA select
    s[7:6] = v[7:6];    // card-detect test
    return s;
  endfunction

  // Standard host-control byte -> vendor host-control halfword (read view).
  function automatic logic [15:0] hc_std_to_vendor(input logic [7:0] s);
    logic [15:0] v;
    v      = '0;
    v[9:8] = s[4:3];
    v[1]   = s[1];
    v[2]   = s[5];
    return v;
  endfunction

  // Expand byte enables into a bit mask.
  function automatic logic [WORD_W-1:0] lane_mask(input logic [LANES-1:0] be);
    logic [WORD_W-1:0] m;
    for (int i = 0; i < LANES; i++) m[i*8 +: 8] = {8{be[i]}};
    return m;
  endfunction

  // Largest SDMA boundary code in block-size bits 14:12.
  function automatic logic [WORD_W-1:0] force_boundary(input logic [WORD_W-1:0] w);
    logic [WORD_W-1:0] r;
    r        = w;
    r[14:12] = 3'b111;
    return r;
  endfunction

endpackage

// File: rtl/vhc_decode.sv
`timescale 1ns/1ps
module vhc_decode
  import vhc_remap_pkg::*;
#(
  parameter int                       ADDR_W    = 8,
  parameter int                       NUM_VEND  = 5,
  parameter logic [ADDR_W-1:0]        HC_OFF    = 8'h28,
  parameter logic [ADDR_W-1:0]        MIX_OFF   = 8'h48,
  parameter logic [ADDR_W-1:0]        XFER_OFF  = 8'h0C,
  parameter logic [ADDR_W-1:0]        BLK_OFF   = 8'h04,
  parameter logic [NUM_VEND*ADDR_W-1:0] VEND_OFFS = 40'h60_68_C0_CC_44
) (
  input  logic [ADDR_W-3:0] waddr,
  output acc_kind_e         kind
);
  localparam int WA = ADDR_W - 2;

  logic [NUM_VEND-1:0] vend_hit;

  for (genvar g = 0; g < NUM_VEND; g++) begin : g_vend
    localparam logic [ADDR_W-1:0] OFF = VEND_OFFS[g*ADDR_W +: ADDR_W];
    assign vend_hit[g] = (waddr == OFF[ADDR_W-1:2]);
  end

  always_comb begin
    if      (waddr == HC_OFF[ADDR_W-1:2])   kind = K_HOSTCTL;
    else if (waddr == MIX_OFF[ADDR_W-1:2])  kind = K_MIXCTL;
    else if (waddr == XFER_OFF[ADDR_W-1:2]) kind = K_XFERCMD;
    else if (waddr == BLK_OFF[ADDR_W-1:2])  kind = K_BLKSIZE;
    else if (|vend_hit)                     kind = K_VENDOR;
    else                                    kind = K_PASS;
  end

  // Word address width sanity (static).
  initial begin
    assert (WA >= 1) else $error("address too narrow");
  end
endmodule

// File: rtl/vhc_mode_cache.sv
`timescale 1ns/1ps
module vhc_mode_cache #(
  parameter int MODE_W = 16
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_en,
  input  logic [MODE_W/8-1:0] lane_en,
  input  logic [MODE_W-1:0]   wdata,
  output logic [MODE_W-1:0]   mode_q
);
  localparam int NL = MODE_W / 8;

  for (genvar g = 0; g < NL; g++) begin : g_lane
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                   mode_q[g*8 +: 8] <= '0;
      else if (wr_en && lane_en[g]) mode_q[g*8 +: 8] <= wdata[g*8 +: 8];
    end
  end

  // R5: without a mixed-control write the cached mode must hold.
  p_mode_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(mode_q));
  // R5: a full-lane write is captured exactly.
  p_mode_load_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && &lane_en) |=> mode_q == $past(wdata));
endmodule

// File: rtl/vhc_wr_xlate.sv
`timescale 1ns/1ps
module vhc_wr_xlate
  import vhc_remap_pkg::*;
(
  input  logic              up_valid,
  input  logic              up_write,
  input  acc_kind_e         kind,
  input  logic [LANES-1:0]  up_be,
  input  logic [WORD_W-1:0] up_wdata,
  input  logic [7:0]        std_power,
  input  logic [MODE_W-1:0] mode_q,
  output logic              dn_valid,
  output logic [LANES-1:0]  dn_be,
  output logic [WORD_W-1:0] dn_wdata,
  output logic              mode_wr_en
);
  logic absorbed;
  logic cmd_upper;
  logic [WORD_W-1:0] en_data;

  assign absorbed   = (kind == K_VENDOR) || (kind == K_MIXCTL);
  assign dn_valid   = up_valid && !absorbed;
  assign mode_wr_en = up_valid && up_write && (kind == K_MIXCTL);
  assign cmd_upper  = up_be[2] || up_be[3];
  assign en_data    = up_wdata & lane_mask(up_be);

  always_comb begin
    dn_be    = up_be;
    dn_wdata = up_wdata;
    if (up_write) begin
      unique case (kind)
        K_HOSTCTL: dn_wdata = {up_wdata[31:16], std_power,
                               hc_vendor_to_std(up_wdata[15:0])};
        K_XFERCMD: if (cmd_upper) begin
          dn_be    = up_be | 4'b0011;
          dn_wdata = {up_wdata[31:16], en_data[15:0] | mode_q};
        end
        K_BLKSIZE: dn_wdata = force_boundary(up_wdata);
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/vhc_rd_xlate.sv
`timescale 1ns/1ps
module vhc_rd_xlate
  import vhc_remap_pkg::*;
(
  input  acc_kind_e         kind,
  input  logic [WORD_W-1:0] dn_rdata,
  output logic [WORD_W-1:0] up_rdata
);
  always_comb begin
    unique case (kind)
      K_HOSTCTL: up_rdata = {dn_rdata[31:16], hc_std_to_vendor(dn_rdata[7:0])};
      K_VENDOR,
      K_MIXCTL:  up_rdata = '0;
      default:   up_rdata = dn_rdata;
    endcase
  end
endmodule

// File: rtl/vhc_remap.sv
`timescale 1ns/1ps
module vhc_remap
  import vhc_remap_pkg::*;
#(
  parameter int                         ADDR_W    = 8,
  parameter int                         NUM_VEND  = 5,
  parameter logic [ADDR_W-1:0]          HC_OFF    = 8'h28,
  parameter logic [ADDR_W-1:0]          MIX_OFF   = 8'h48,
  parameter logic [ADDR_W-1:0]          XFER_OFF  = 8'h0C,
  parameter logic [ADDR_W-1:0]          BLK_OFF   = 8'h04,
  parameter logic [NUM_VEND*ADDR_W-1:0] VEND_OFFS = 40'h60_68_C0_CC_44
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              up_valid,
  input  logic              up_write,
  input  logic [ADDR_W-1:0] up_addr,
  input  logic [3:0]        up_be,
  input  logic [31:0]       up_wdata,
  output logic [31:0]       up_rdata,
  input  logic [7:0]        std_power,
  output logic              dn_valid,
  output logic              dn_write,
  output logic [ADDR_W-1:0] dn_addr,
  output logic [3:0]        dn_be,
  output logic [31:0]       dn_wdata,
  input  logic [31:0]       dn_rdata
);
  acc_kind_e         kind;
  logic [MODE_W-1:0] mode_q;
  logic              mode_wr_en;

  assign dn_write = up_write;
  assign dn_addr  = up_addr;

  vhc_decode #(
    .ADDR_W(ADDR_W), .NUM_VEND(NUM_VEND), .HC_OFF(HC_OFF), .MIX_OFF(MIX_OFF),
    .XFER_OFF(XFER_OFF), .BLK_OFF(BLK_OFF), .VEND_OFFS(VEND_OFFS)
  ) u_decode (
    .waddr (up_addr[ADDR_W-1:2]),
    .kind  (kind)
  );

  vhc_mode_cache #(.MODE_W(MODE_W)) u_cache (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (mode_wr_en),
    .lane_en (up_be[1:0]),
    .wdata   (up_wdata[15:0]),
    .mode_q  (mode_q)
  );

  vhc_wr_xlate u_wr (
    .up_valid   (up_valid),
    .up_write   (up_write),
    .kind       (kind),
    .up_be      (up_be),
    .up_wdata   (up_wdata),
    .std_power  (std_power),
    .mode_q     (mode_q),
    .dn_valid   (dn_valid),
    .dn_be      (dn_be),
    .dn_wdata   (dn_wdata),
    .mode_wr_en (mode_wr_en)
  );

  vhc_rd_xlate u_rd (
    .kind     (kind),
    .dn_rdata (dn_rdata),
    .up_rdata (up_rdata)
  );

  // R1: ordinary addresses are forwarded untouched.
  p_pass_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (up_valid && kind == K_PASS) |->
      (dn_valid && dn_be == up_be && dn_wdata == up_wdata && up_rdata == dn_rdata));
  // R3: host-control writes carry the power byte and keep the upper half.
  p_hc_power_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (up_valid && up_write && kind == K_HOSTCTL) |->
      (dn_valid && dn_wdata[15:8] == std_power && dn_wdata[31:16] == up_wdata[31:16]));
  // R5: mixed-control accesses never reach the standard controller.
  p_mix_absorb_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (up_valid && kind == K_MIXCTL) |-> (!dn_valid && up_rdata == '0));
  // R6: every forwarded command-word write contains all cached mode bits.
  p_cmd_merge_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (dn_valid && dn_write && kind == K_XFERCMD && (up_be[2] || up_be[3])) |->
      ((dn_wdata[15:0] & mode_q) == mode_q && dn_be[1:0] == 2'b11));
  // R7: forwarded block-size writes carry the largest boundary code.
  p_boundary_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (dn_valid && dn_write && kind == K_BLKSIZE) |-> dn_wdata[14:12] == 3'b111);
  // R8: vendor-only registers are quiet and read as zero.
  p_vendor_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (up_valid && kind == K_VENDOR) |-> (!dn_valid && up_rdata == '0));
endmodule

// File: tb/vhc_remap_tb_top.sv
`timescale 1ns/1ps
module vhc_remap_tb_top;

  localparam logic [7:0] A_HC   = 8'h28;
  localparam logic [7:0] A_MIX  = 8'h48;
  localparam logic [7:0] A_XFER = 8'h0C;
  localparam logic [7:0] A_BLK  = 8'h04;
  localparam logic [7:0] A_V0 = 8'h60, A_V1 = 8'h68, A_V2 = 8'hC0, A_V3 = 8'hCC, A_V4 = 8'h44;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        up_valid = 1'b0, up_write = 1'b0;
  logic [7:0]  up_addr = '0;
  logic [3:0]  up_be = '0;
  logic [31:0] up_wdata = '0;
  logic [31:0] up_rdata;
  logic [7:0]  std_power = 8'h00;
  logic        dn_valid, dn_write;
  logic [7:0]  dn_addr;
  logic [3:0]  dn_be;
  logic [31:0] dn_wdata;
  logic [31:0] dn_rdata;

  int checks = 0, fails = 0;
  bit done = 0;
  int mode_ref = 0;          // reference cache of the transfer mode
  logic [31:0] stub [64];    // standard register-file stub

  always #5 clk = ~clk;

  vhc_remap #(
    .ADDR_W(8), .NUM_VEND(5), .HC_OFF(A_HC), .MIX_OFF(A_MIX), .XFER_OFF(A_XFER),
    .BLK_OFF(A_BLK), .VEND_OFFS({A_V0, A_V1, A_V2, A_V3, A_V4})
  ) dut_i (
    .clk(clk), .rst_n(rst_n), .up_valid(up_valid), .up_write(up_write),
    .up_addr(up_addr), .up_be(up_be), .up_wdata(up_wdata), .up_rdata(up_rdata),
    .std_power(std_power), .dn_valid(dn_valid), .dn_write(dn_write),
    .dn_addr(dn_addr), .dn_be(dn_be), .dn_wdata(dn_wdata), .dn_rdata(dn_rdata)
  );

  assign dn_rdata = stub[dn_addr[7:2]];

  always @(posedge clk) begin
    if (dn_valid && dn_write)
      for (int i = 0; i < 4; i++)
        if (dn_be[i]) stub[dn_addr[7:2]][i*8 +: 8] <= dn_wdata[i*8 +: 8];
  end

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic bit is_vendor(input logic [7:0] a);
    return a[7:2] == A_V0[7:2] || a[7:2] == A_V1[7:2] || a[7:2] == A_V2[7:2] ||
           a[7:2] == A_V3[7:2] || a[7:2] == A_V4[7:2];
  endfunction

  // One access, compared against the reference in the cycle it is issued.
  task automatic xact(input string req, input bit w, input logic [7:0] a,
                      input logic [3:0] be, input logic [31:0] d);
    bit          ev;
    logic [3:0]  ebe;
    logic [31:0] ewd, erd, s, msk;
    @(negedge clk);
    up_valid = 1'b1; up_write = w; up_addr = a; up_be = be; up_wdata = d;
    #1;
    s   = stub[a[7:2]];
    msk = {{8{be[3]}}, {8{be[2]}}, {8{be[1]}}, {8{be[0]}}};
    ev = 1'b1; ebe = be; ewd = d; erd = s;
    if (a[7:2] == A_HC[7:2]) begin
      ewd = {d[31:16], std_power, d[7], d[6], d[2], d[9], d[8], 1'b0, d[1], d[0]};
      erd = {s[31:24], s[23:16], 6'd0, s[4], s[3], 5'd0, s[5], s[1], 1'b0};
    end else if (a[7:2] == A_MIX[7:2]) begin
      ev = 1'b0; erd = 32'd0;
    end else if (a[7:2] == A_XFER[7:2]) begin
      if (w && (be[3] | be[2])) begin
        ebe = be | 4'h3;
        ewd = {d[31:16], 16'((d & msk) | mode_ref)};
      end
    end else if (a[7:2] == A_BLK[7:2]) begin
      if (w) ewd = d | 32'h0000_7000;
    end else if (is_vendor(a)) begin
      ev = 1'b0; erd = 32'd0;
    end
    check(req, "dn_valid", {31'd0, dn_valid}, {31'd0, ev});
    if (ev) begin
      check(req, "dn_addr/write", {23'd0, dn_write, dn_addr}, {23'd0, w, a});
      if (w) begin
        check(req, "dn_be", {28'd0, dn_be}, {28'd0, ebe});
        check(req, "dn_wdata", dn_wdata, ewd);
      end
    end
    if (!w) check(req, "up_rdata", up_rdata, erd);
    @(posedge clk);
    if (w && a[7:2] == A_MIX[7:2]) begin
      if (be[0]) mode_ref = (mode_ref & 'hFF00) | (d & 'h00FF);
      if (be[1]) mode_ref = (mode_ref & 'h00FF) | (d & 'hFF00);
    end
    #1 up_valid = 1'b0;
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 64; i++) stub[i] = (i * 32'h0103_0507) ^ 32'h5AC3_96E1;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    // R9: cache empty after reset
    xact("R9", 1, A_XFER, 4'hF, 32'h1234_0000);
    // R1: plain addresses
    xact("R1", 1, 8'h20, 4'hF, 32'hDEAD_BEEF);
    xact("R1", 0, 8'h20, 4'hF, 32'h0);
    xact("R1", 1, 8'h30, 4'h4, 32'h00AA_0000);
    xact("R1", 0, 8'h30, 4'hF, 32'h0);
    // R5: mixed-control write cached, read zero
    xact("R5", 1, A_MIX, 4'h3, 32'h00AB_0031);
    xact("R5", 0, A_MIX, 4'hF, 32'h0);
    // R6: merged into command write
    xact("R6", 1, A_XFER, 4'hC, 32'h0512_FFFF);
    xact("R5", 1, A_MIX, 4'h2, 32'h0000_7799);
    xact("R6", 1, A_XFER, 4'hF, 32'h1A00_0100);
    xact("R6", 1, A_XFER, 4'h3, 32'h0000_0002);
    // R2 R3: host-control write patterns, then R4 read-back
    std_power = 8'h0F;
    xact("R2", 1, A_HC, 4'hF, 32'h5A5A_03C7);
    xact("R4", 0, A_HC, 4'hF, 32'h0);
    std_power = 8'hB2;
    xact("R3", 1, A_HC, 4'hF, 32'h1234_0106);
    xact("R4", 0, A_HC, 4'hF, 32'h0);
    xact("R2", 1, A_HC, 4'hF, 32'hFFFF_FFFF);
    xact("R4", 0, A_HC, 4'hF, 32'h0);
    xact("R2", 1, A_HC, 4'h3, 32'h0000_0200);
    xact("R4", 0, A_HC, 4'hF, 32'h0);
    // R7: boundary forced
    xact("R7", 1, A_BLK, 4'hF, 32'h0001_0200);
    xact("R7", 1, A_BLK, 4'h3, 32'h0000_0000);
    xact("R1", 0, A_BLK, 4'hF, 32'h0);
    // R8: vendor-only registers
    xact("R8", 1, A_V0, 4'hF, 32'hFFFF_FFFF);
    xact("R8", 0, A_V0, 4'hF, 32'h0);
    xact("R8", 1, A_V1, 4'hF, 32'h1111_1111);
    xact("R8", 0, A_V1, 4'hF, 32'h0);
    xact("R8", 1, A_V2, 4'h1, 32'h0000_0077);
    xact("R8", 0, A_V2, 4'hF, 32'h0);
    xact("R8", 1, A_V3, 4'hF, 32'h0BAD_F00D);
    xact("R8", 0, A_V3, 4'hF, 32'h0);
    xact("R8", 1, A_V4, 4'hF, 32'hCAFE_0001);
    xact("R8", 0, A_V4, 4'hF, 32'h0);
    // mixed sweep over host-control and plain words
    for (int k = 0; k < 24; k++) begin
      logic [31:0] pat;
      pat = 32'h9E37_79B9 * (k + 1);
      std_power = pat[27:20];
      xact("R2", 1, A_HC, 4'hF, pat);
      xact("R4", 0, A_HC, 4'hF, 32'h0);
      xact("R1", 1, 8'(8'h80 + 4 * k), 4'(k), pat ^ 32'h0F0F_0F0F);
      xact("R1", 0, 8'(8'h80 + 4 * k), 4'hF, 32'h0);
    end
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule